// File: doc/BRIEF.md
# Command-Driven Byte-Wide Flash Model

This block models a byte-wide non-volatile memory that is driven entirely by commands. Every byte written on a small synchronous bus is decoded as a command or as the data phase of a two-write sequence. A current-mode register decides what a read returns: stored array bytes, a status byte, or one of two identifier bytes. Byte programming and block erase each take two bus writes. Program errors cannot occur. A malformed erase sequence sets sticky error flags in the status byte.

The array is an internal register file. Its size, the erase block size, the bus address width and the 16-bit identifier are parameters. A confirmed erase runs as a sweep that clears one byte per clock. While the sweep runs, `busy` is high and the bus ignores writes. Read data is registered and appears one cycle after the read strobe.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the mode is array read, both error flags are clear, the sequence is in its first write, `busy` is low and every array byte reads 0xFF.
- R2: First-write bytes 0xFF (array read), 0x70 (status read), 0x90 (identifier read) and 0xB0 (suspend/resume) only replace the mode. A first-write byte outside the command set changes nothing.
- R3: First-write byte 0x50 clears both error flags and selects array read mode.
- R4: After 0x40 or 0x10, the next write stores its data byte at its address if the address is below MEM_BYTES. Otherwise that write is dropped. Programming never sets an error flag. The mode stays at the program command, so reads return 0xFF until a new mode command arrives.
- R5: After 0x20, a second write of 0xD0 sets every byte of the block containing its address to 0xFF. The block base is the address with its low log2(BLK_BYTES) bits cleared. `busy` is high for exactly BLK_BYTES cycles starting the cycle after the confirm write. Bytes outside the block keep their values.
- R6: After 0x20, a second write of any byte other than 0xD0 selects status read mode and sets status bit 5 (erase error) and bit 4 (program error). Both bits stay set until 0x50 is written.
- R7: Every second write returns the sequence to its first write, so the byte after it is decoded as a command.
- R8: While `busy` is high, bus writes change neither the mode, the flags, the sequence state nor the array.
- R9: Reads return the following. In array mode: the stored byte, or 0xFF at addresses of MEM_BYTES or above. In status mode: the status byte. In identifier mode: DEV_ID[15:8] when address bit 0 is 1, otherwise DEV_ID[7:0]. In every other mode: 0xFF.
- R10: `rd_data` updates on the clock edge that samples `rd_en`, holds its value while `rd_en` is low, and reads never change mode, flags or sequence state.
- R11: Status bit 7 equals the inverse of `busy`. Bits 6 and 3 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address for reads and writes |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrData | input | 8 | Command or data byte |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| busy | output | 1 | Erase sweep in progress |

## Verification
The bench builds the block with MEM_BYTES=96, BLK_BYTES=16, ADDR_W=8 and DEV_ID=16'hC3A5. Because the array size is not a power of two, addresses 96 to 255 are reachable on the bus and exercise both the dropped-program and the 0xFF-read paths. An erase aimed at those addresses touches no stored byte. The 16-byte blocks keep each sweep short, so a random run completes many erases, and writes can land inside the busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [7:0] {
    MODE_ARRAY    = 8'hFF,
    MODE_STATUS   = 8'h70,
    MODE_ID       = 8'h90,
    MODE_SUSPEND  = 8'hB0,
    MODE_PROG     = 8'h40,
    MODE_PROG_ALT = 8'h10,
    MODE_ERASE    = 8'h20
  } mode_e;

  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  typedef struct packed {
    logic prog;
    logic erase;
  } strobe_t;
endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       eraseBusy,
  output strobe_t    stb,
  output mode_e      mode,
  output logic       secondCycle,
  output logic [7:0] statusByte
);
  logic eraseErr;
  logic progErr;
  logic accept;

  assign accept     = wrEn && !eraseBusy;
  assign statusByte = {!eraseBusy, 1'b0, eraseErr, progErr, 4'b0000};

  always_comb begin
    stb = '0;
    if (accept && secondCycle) begin
      if (mode == MODE_PROG || mode == MODE_PROG_ALT) stb.prog = 1'b1;
      if (mode == MODE_ERASE && wrData == CMD_CONFIRM) stb.erase = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode        <= MODE_ARRAY;
      secondCycle <= 1'b0;
      eraseErr    <= 1'b0;
      progErr     <= 1'b0;
    end else if (accept) begin
      if (!secondCycle) begin
        case (wrData)
          8'hFF, 8'h70, 8'h90, 8'hB0: mode <= mode_e'(wrData);
          CMD_CLEAR: begin
            eraseErr <= 1'b0;
            progErr  <= 1'b0;
            mode     <= MODE_ARRAY;
          end
          8'h40, 8'h10, 8'h20: begin
            mode        <= mode_e'(wrData);
            secondCycle <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        secondCycle <= 1'b0;
        if (mode == MODE_ERASE && wrData != CMD_CONFIRM) begin
          mode     <= MODE_STATUS;
          eraseErr <= 1'b1;
          progErr  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_data.sv
module flash_data
  import flash_cmd_pkg::*;
#(
  parameter int          MEM_BYTES = 256,
  parameter int          BLK_BYTES = 32,
  parameter int          ADDR_W    = 9,
  parameter logic [15:0] DEV_ID    = 16'h89A2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  mode_e             mode,
  input  logic [7:0]        statusByte,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              eraseBusy
);
  localparam int                IDX_W    = $clog2(MEM_BYTES);
  localparam int                BLK_W    = $clog2(BLK_BYTES);
  localparam logic [ADDR_W:0]   MEM_LIM  = (ADDR_W+1)'(MEM_BYTES);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);
  localparam logic [BLK_W-1:0]  PTR_LAST = BLK_W'(BLK_BYTES - 1);

  logic [7:0]        mem [0:MEM_BYTES-1];
  logic [ADDR_W-1:0] sweepBase;
  logic [BLK_W-1:0]  sweepPtr;
  logic [ADDR_W-1:0] sweepAddr;
  logic              busInRange;
  logic              sweepInRange;
  logic [7:0]        readMux;

  assign sweepAddr    = sweepBase | ADDR_W'(sweepPtr);
  assign busInRange   = {1'b0, busAddr} < MEM_LIM;
  assign sweepInRange = {1'b0, sweepAddr} < MEM_LIM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBusy <= 1'b0;
      sweepBase <= '0;
      sweepPtr  <= '0;
    end else if (stb.erase) begin
      eraseBusy <= 1'b1;
      sweepBase <= busAddr & BLK_MASK;
      sweepPtr  <= '0;
    end else if (eraseBusy) begin
      sweepPtr <= sweepPtr + 1'b1;
      if (sweepPtr == PTR_LAST) eraseBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (stb.prog && busInRange) begin
      mem[busAddr[IDX_W-1:0]] <= wrData;
    end else if (eraseBusy && sweepInRange) begin
      mem[sweepAddr[IDX_W-1:0]] <= 8'hFF;
    end
  end

  always_comb begin
    case (mode)
      MODE_ARRAY:  readMux = busInRange ? mem[busAddr[IDX_W-1:0]] : 8'hFF;
      MODE_STATUS: readMux = statusByte;
      MODE_ID:     readMux = busAddr[0] ? DEV_ID[15:8] : DEV_ID[7:0];
      default:     readMux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= 8'hFF;
    else if (rdEn) rdData <= readMux;
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int          MEM_BYTES = 256,
  parameter int          BLK_BYTES = 32,
  parameter int          ADDR_W    = 9,
  parameter logic [15:0] DEV_ID    = 16'h89A2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              busy
);
  strobe_t    stb;
  mode_e      modeQ;
  logic       phase2;
  logic [7:0] statusByte;

  flash_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .eraseBusy(busy),
    .stb(stb), .mode(modeQ), .secondCycle(phase2), .statusByte(statusByte)
  );

  flash_data #(
    .MEM_BYTES(MEM_BYTES), .BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W), .DEV_ID(DEV_ID)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(modeQ), .statusByte(statusByte),
    .busAddr(busAddr), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .eraseBusy(busy)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       busy,
  input logic [7:0] mode,
  input logic       secondCycle,
  input logic [7:0] statusByte
);
  assert_ready_bit_R11: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] == !busy);
  assert_zero_bits_R11: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte & 8'h4F) == 8'h00);
  assert_busy_freezes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> ($stable(mode) && $stable(secondCycle)));
  assert_second_returns_R7: assert property (@(posedge clk) disable iff (!rstN)
    (secondCycle && wrEn && !busy) |=> !secondCycle);
  assert_erase_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(secondCycle) && $past(wrData) == 8'hD0 && $past(mode) == 8'h20));
  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
  assert_read_no_side_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> ($stable(mode) && $stable(secondCycle) && $stable(statusByte[5:4])));
endmodule

bind flash_cmd_if flash_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
  .rdData(rdData), .busy(busy), .mode(modeQ), .secondCycle(phase2),
  .statusByte(statusByte)
);

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;
  localparam int          MB   = 96;
  localparam int          BLK  = 16;
  localparam int          AW   = 8;
  localparam logic [15:0] DID  = 16'hC3A5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          wrEn = 1'b0;
  logic [7:0]    wrData = '0;
  logic          rdEn = 1'b0;
  logic [7:0]    rdData;
  logic          busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] mm [0:MB-1];
  logic [7:0] md;
  bit ph, es, bw;
  int bcnt;
  logic [7:0] expRd;

  always #5 clk = ~clk;

  flash_cmd_if #(.MEM_BYTES(MB), .BLK_BYTES(BLK), .ADDR_W(AW), .DEV_ID(DID)) i_flash_cmd_if (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .busy(busy)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdModel(int a);
    case (md)
      8'hFF:   return (a < MB) ? mm[a] : 8'hFF;
      8'h70:   return {(bcnt == 0), 1'b0, es, bw, 4'b0000};
      8'h90:   return a[0] ? DID[15:8] : DID[7:0];
      default: return 8'hFF;
    endcase
  endfunction

  function automatic void cmdModel(int a, logic [7:0] d);
    if (!ph) begin
      case (d)
        8'hFF, 8'h70, 8'h90, 8'hB0: md = d;
        8'h50: begin es = 0; bw = 0; md = 8'hFF; end
        8'h40, 8'h10, 8'h20: begin md = d; ph = 1; end
        default: ;
      endcase
    end else begin
      ph = 0;
      if (md == 8'h40 || md == 8'h10) begin
        if (a < MB) mm[a] = d;
      end else if (md == 8'h20) begin
        if (d == 8'hD0) begin
          for (int i = 0; i < BLK; i++)
            if ((a & ~(BLK - 1)) + i < MB) mm[(a & ~(BLK - 1)) + i] = 8'hFF;
          bcnt = BLK;
        end else begin
          md = 8'h70; es = 1; bw = 1;
        end
      end
    end
  endfunction

  task automatic cyc(bit w, int a, logic [7:0] d, bit r, string tag);
    busAddr = AW'(a); wrEn = w; wrData = d; rdEn = r;
    @(posedge clk);
    if (r) expRd = rdModel(a);
    if (bcnt > 0) bcnt--;
    else if (w) cmdModel(a, d);
    @(negedge clk);
    chk("R5 busy", {7'b0, busy}, {7'b0, (bcnt > 0)});
    chk(tag, rdData, expRd);
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(int a, logic [7:0] d, string tag); cyc(1, a, d, 0, tag); endtask
  task automatic rd(int a, string tag); cyc(0, a, 8'h00, 1, tag); endtask
  task automatic idle(string tag); cyc(0, 0, 8'h00, 0, tag); endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MB; i++) mm[i] = 8'hFF;
    md = 8'hFF; ph = 0; es = 0; bw = 0; bcnt = 0; expRd = 8'hFF;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", {7'b0, busy}, 8'h00);
    rd(0, "R1 array");
    rd(95, "R1 last byte");
    wr(0, 8'h70, "R1");
    rd(0, "R1 R11 status");
    wr(0, 8'h90, "R2");
    rd(0, "R9 id low");
    rd(1, "R9 id high");
    wr(3, 8'h33, "R2");
    rd(7, "R2 unknown ignored");
    wr(0, 8'hB0, "R2");
    rd(2, "R9 other mode");
    wr(0, 8'hFF, "R2");
    wr(0, 8'h40, "R4");
    wr(5, 8'h3C, "R4");
    rd(5, "R4 stays program mode");
    wr(0, 8'hFF, "R4");
    rd(5, "R4 stored");
    wr(0, 8'h10, "R4");
    wr(200, 8'h11, "R4");
    wr(0, 8'hFF, "R4");
    rd(200, "R4 R9 beyond array");
    wr(0, 8'h70, "R4");
    rd(0, "R4 no error");
    wr(0, 8'h40, "R7");
    wr(6, 8'h70, "R7");
    wr(0, 8'hFF, "R7");
    rd(6, "R7 data stored");
    wr(0, 8'h40, "R5"); wr(20, 8'hAB, "R5");
    wr(0, 8'h40, "R5"); wr(40, 8'hCD, "R5");
    wr(0, 8'h20, "R5");
    wr(25, 8'hD0, "R5");
    wr(0, 8'hFF, "R8");
    wr(0, 8'h50, "R8");
    repeat (BLK) idle("R5");
    rd(20, "R8 mode held");
    wr(0, 8'hFF, "R5");
    rd(20, "R5 erased");
    rd(16, "R5 block base");
    rd(40, "R5 neighbour kept");
    wr(0, 8'h20, "R6");
    wr(0, 8'h55, "R6");
    rd(0, "R6 flags");
    wr(0, 8'hFF, "R6");
    wr(0, 8'h70, "R6");
    rd(0, "R6 sticky");
    wr(0, 8'h50, "R3");
    rd(40, "R3 array mode");
    wr(0, 8'h70, "R3");
    rd(0, "R3 cleared");
    rd(0, "R10 repeat");
    idle("R10 hold");
    for (int n = 0; n < 4000; n++) begin
      int sel;
      int a;
      logic [7:0] d;
      sel = int'($urandom % 16);
      a = int'($urandom % 256);
      d = 8'($urandom);
      if (sel < 6) rd(a, "R9 random");
      else if (sel < 9) begin
        case ($urandom % 9)
          0: d = 8'hFF; 1: d = 8'h70; 2: d = 8'h90; 3: d = 8'hB0;
          4: d = 8'h50; 5: d = 8'h40; 6: d = 8'h10; 7: d = 8'h20;
          default: ;
        endcase
        wr(a, d, "R2 random");
      end else begin
        if (ph && md == 8'h20 && ($urandom % 4 != 0)) d = 8'hD0;
        wr(a, d, "R4 random");
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule